// File: doc/BRIEF.md
# Start-free four-press combination lock

This block is a Moore state machine that watches two button-pulse inputs, one for the digit 0 and one for the digit 1. It raises `unlock` while the four most recent presses, oldest first, read 0, 1, 1, 0. There is no start button. The machine keeps matching through every press, so the code can be typed after any amount of earlier input, and a code entered straight after a match can reuse the end of that match.

The state counts how much of the code is matched at the end of the press history. A press moves the state. A cycle with no press, or with both buttons pulsed at once, leaves the state as it is. Three of the eight 3-bit encodings are not used. Each of them has a defined exit, so the lock settles into a legal state on the first press even if the flip-flops power up with random contents. The inputs are expected to be clean one-cycle pulses that are already synchronous to `clk`.

Top module: `pattern_lock`

## Requirements
- R1: `unlock` is 1 if and only if the four most recent presses, oldest first, were 0,1,1,0. Earlier history has no effect, and no start press is needed.
- R2: After a full match, a press of 1, then 1, then 0 unlocks again, because the trailing "0" of the match is reused. A 0 press in the full-match state leaves one symbol matched.
- R3: There are five states, encoded in 3 bits: nothing matched = 000, one matched = 001, two matched = 010, three matched = 011, all four matched = 100. `unlock` is 1 only in state 100.
- R4: A cycle where neither pulse is high, or where both are high, leaves the state unchanged, and `unlock` stays as it was.
- R5: From an unused encoding (101, 110, 111), a 0 press goes to 001 and a 1 press goes to 000.
- R6: A synchronous reset forces state 000. While reset is high, `unlock` is 0.
- R7: `unlock` is a function of the current state only. A change on a button input has no effect on `unlock` before the next clock edge.
- R8: A press that breaks a partial match falls back to the longest matching suffix. A 1 after "011" falls back to 000. A 0 after "01" falls back to 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn0_pulse | input | 1 | One-cycle pulse for a press of digit 0 |
| btn1_pulse | input | 1 | One-cycle pulse for a press of digit 1 |
| unlock | output | 1 | High while the last four presses were 0,1,1,0 |

## Verification
The match count is held internally, so a wrong count shows at the port only as an `unlock` that arrives early, arrives late, or never arrives. A wrong fallback on a broken partial match may stay hidden for up to three more presses and then show as a missed or spurious unlock on the fourth. The stimulus therefore runs press streams with overlapping codes, broken prefixes and idle or double-press cycles mixed in, and compares `unlock` after every edge. It also drives the next-state logic on its own with the three unused encodings, because no sequence at the top-level ports can reach them.

// File: rtl/pattern_lock_pkg.sv
package pattern_lock_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_NONE  = 3'b000,
        ST_ONE   = 3'b001,
        ST_TWO   = 3'b010,
        ST_THREE = 3'b011,
        ST_FULL  = 3'b100
    } lock_state_t;

    typedef struct packed {
        lock_state_t st;
    } lock_regs_t;

endpackage

// File: rtl/pattern_lock_btn.sv
module pattern_lock_btn (
    input  logic b0_i,
    input  logic b1_i,
    output logic press_o,
    output logic bit_o
);
    // exactly one pulse counts as a press; both or none is ignored
    always_comb begin
        press_o = b0_i ^ b1_i;
        bit_o   = b1_i;
    end
endmodule

// File: rtl/pattern_lock_next.sv
module pattern_lock_next
    import pattern_lock_pkg::*;
(
    input  lock_state_t cur_i,
    input  logic        press_i,
    input  logic        bit_i,
    output lock_state_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (press_i) begin
            unique case (cur_i)
                ST_NONE:  nxt_o = bit_i ? ST_NONE  : ST_ONE;
                ST_ONE:   nxt_o = bit_i ? ST_TWO   : ST_ONE;
                ST_TWO:   nxt_o = bit_i ? ST_THREE : ST_ONE;
                ST_THREE: nxt_o = bit_i ? ST_NONE  : ST_FULL;
                ST_FULL:  nxt_o = bit_i ? ST_TWO   : ST_ONE;
                default:  nxt_o = bit_i ? ST_NONE  : ST_ONE;
            endcase
        end
    end
endmodule

// File: rtl/pattern_lock_out.sv
module pattern_lock_out
    import pattern_lock_pkg::*;
(
    input  lock_state_t st_i,
    input  logic        rst_i,
    output logic        unlock_o
);
    always_comb begin
        unlock_o = (st_i == ST_FULL) && !rst_i;
    end
endmodule

// File: rtl/pattern_lock.sv
module pattern_lock
    import pattern_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn0_pulse,
    input  logic btn1_pulse,
    output logic unlock
);
    lock_regs_t  regs_d, regs_q;
    logic        press, press_bit;
    lock_state_t st_next;

    pattern_lock_btn u_btn (
        .b0_i    (btn0_pulse),
        .b1_i    (btn1_pulse),
        .press_o (press),
        .bit_o   (press_bit)
    );

    pattern_lock_next u_next (
        .cur_i   (regs_q.st),
        .press_i (press),
        .bit_i   (press_bit),
        .nxt_o   (st_next)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = st_next;
        if (rst) begin
            regs_d.st = ST_NONE;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    pattern_lock_out u_out (
        .st_i     (regs_q.st),
        .rst_i    (rst),
        .unlock_o (unlock)
    );
endmodule

// File: rtl/pattern_lock_chk.sv
module pattern_lock_chk
    import pattern_lock_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        btn0_pulse,
    input logic        btn1_pulse,
    input lock_state_t state,
    input logic        unlock
);
    p_legal_state_r3: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_NONE, ST_ONE, ST_TWO, ST_THREE, ST_FULL}));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !(btn0_pulse ^ btn1_pulse) |=> $stable(state));

    p_zero_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (btn0_pulse && !btn1_pulse && state != ST_THREE) |=> state == ST_ONE);

    p_one_fallback_r8: assert property (@(posedge clk) disable iff (rst)
        (btn1_pulse && !btn0_pulse && (state == ST_NONE || state == ST_THREE)) |=> state == ST_NONE);

    p_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        (btn1_pulse && !btn0_pulse && state == ST_FULL) |=> state == ST_TWO);

    p_open_cause_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> ($past(btn0_pulse && !btn1_pulse) && $past(state) == ST_THREE));

    p_quiet_reset_r6: assert property (@(posedge clk)
        rst |-> !unlock);
endmodule

bind pattern_lock pattern_lock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .btn0_pulse (btn0_pulse),
    .btn1_pulse (btn1_pulse),
    .state      (regs_q.st),
    .unlock     (unlock)
);

// File: tb/sim_pattern_lock.sv
module sim_pattern_lock;
    import pattern_lock_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b0  = 1'b0;
    logic b1  = 1'b0;
    logic unlock;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pattern_lock u0 (
        .clk        (clk),
        .rst        (rst),
        .btn0_pulse (b0),
        .btn1_pulse (b1),
        .unlock     (unlock)
    );

    // next-state logic alone, used to reach the unused codes
    lock_state_t nx_cur, nx_out;
    logic        nx_press = 1'b0, nx_bit = 1'b0;
    pattern_lock_next u1 (
        .cur_i   (nx_cur),
        .press_i (nx_press),
        .bit_i   (nx_bit),
        .nxt_o   (nx_out)
    );

    // entries {b1, b0, expected unlock after the edge}
    localparam int NV = 24;
    localparam logic [2:0] VEC [NV] = '{
        3'b010, 3'b100, 3'b100, 3'b011,   // 0110 -> open (R1)
        3'b001, 3'b111,                   // idle, both held (R4)
        3'b100, 3'b100, 3'b011,           // overlap 1,1,0 (R2)
        3'b010, 3'b010, 3'b100, 3'b010,   // 0 after 01 falls to one (R8)
        3'b100, 3'b100, 3'b100,           // 0111 falls to none (R8)
        3'b010, 3'b000, 3'b100, 3'b110,   // idle and both mid-code (R4)
        3'b100, 3'b000, 3'b011,           // completes 0110 (R1)
        3'b100                            // leaves open (R2)
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: unlock=%b expected %b", req, got, exp);
        end
    endtask

    task automatic check_st(input string req, input lock_state_t got, input lock_state_t exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: next=%b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic p1, input logic p0);
        b1 = p1;
        b0 = p0;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        nx_cur = ST_NONE;
        repeat (2) @(negedge clk);
        check("R6 reset state", unlock, 1'b0);
        rst = 1'b0;

        foreach (VEC[i]) begin
            step(VEC[i][2], VEC[i][1]);
            check($sformatf("R1/R2/R4/R8 vector %0d", i), unlock, VEC[i][0]);
        end
        step(1'b0, 1'b0);

        // reach open, then show inputs do not reach unlock before an edge (R7)
        step(1'b0, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1);
        check("R1 open again", unlock, 1'b1);
        b1 = 1'b1; b0 = 1'b0;
        #3;
        check("R7 no input path", unlock, 1'b1);
        @(negedge clk);
        check("R2 open then 1", unlock, 1'b0);

        // reset while open, and reset beats a press (R6)
        step(1'b1, 1'b0); step(1'b0, 1'b1);
        check("R1 open before reset", unlock, 1'b1);
        b0 = 1'b0; b1 = 1'b0;
        rst = 1'b1;
        #2;
        check("R6 low during reset", unlock, 1'b0);
        b0 = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        b0 = 1'b0;
        #2;
        check("R6 state none after reset", unlock, 1'b0);
        // from none, 1,1,0 must not open; a full 0110 must
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1);
        check("R6 reset cleared progress", unlock, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1);
        check("R1 after reset", unlock, 1'b1);

        // unused encodings through the next-state logic (R5, R3)
        for (int c = 5; c < 8; c++) begin
            nx_cur = lock_state_t'(3'(c));
            nx_press = 1'b1; nx_bit = 1'b0; #1;
            check_st("R5 unused on 0", nx_out, ST_ONE);
            nx_bit = 1'b1; #1;
            check_st("R5 unused on 1", nx_out, ST_NONE);
        end
        nx_cur = ST_THREE; nx_press = 1'b1; nx_bit = 1'b0; #1;
        check_st("R3 three then 0 is full 100", nx_out, ST_FULL);
        nx_press = 1'b0; #1;
        check_st("R4 no press holds", nx_out, ST_THREE);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule